// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is a small memory-mapped register slave that lets a host driver and a companion controller signal each other through one level interrupt. It holds two outbound descriptor words, a control word, an interrupt status word and a software interrupt word. All of them sit behind a single-cycle register bus with address, write enable, write data, read enable and read data.

The interrupt does not follow any status bit. It is a latched level, and only certain writes change it. Writing descriptor B with its doorbell bit set raises it, and so does any write to the software-set offset. Writing the lower bits of the control or status words drops it, and so does any write to the software-clear offset. Every other write leaves the level as it was. On readback, bit 17 of the control word always reads as one. The set and clear offsets both read back the software interrupt word.

Top module: `doorbell_regs`

## Requirements
- R1: After the asynchronous active-low reset, every register reads zero (control reads 0x0002_0000) and `irq` is 0.
- R2: Writes to descriptor A (byte offset 0x28) and descriptor B (0x2C) store the full 32-bit data, and a read returns it. A descriptor A write never changes `irq`.
- R3: A write to descriptor B whose data has bit 29 set makes `irq` 1 at that clock edge. If bit 29 is clear, `irq` keeps its level.
- R4: A write to control (0x4C) stores the data and makes `irq` 0 when data bit 16 is 1. A control read returns the stored value with bit 17 forced to 1.
- R5: A write to interrupt status (0x50) stores the data and makes `irq` 0 when data bit 16 or bit 29 is 1. Otherwise `irq` keeps its level.
- R6: A write to the set offset (0x1F0) ORs the data into the software interrupt word and makes `irq` 1, even for zero data.
- R7: A write to the clear offset (0x1F4) clears the software interrupt bits that are 1 in the data and makes `irq` 0, even for zero data.
- R8: Reads of both 0x1F0 and 0x1F4 return the software interrupt word.
- R9: A read of any other offset returns zero. A write to any other offset changes no register and leaves `irq` unchanged.
- R10: Address bits [1:0] are ignored by both reads and writes.
- R11: `rd_data` is zero when `rd_en` is low. `irq` changes only on a clock edge with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (12) | Byte address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (32) | Combinational read data |
| irq | output | 1 | Latched level interrupt |

## Verification
A wrong stored word shows up on the very next read of its offset. A wrong software interrupt word shows at both of its read offsets. A wrong interrupt decision shows on `irq` half a cycle after the write that caused it, and it stays wrong until a later write forces the level again. For that reason the bench checks `irq` after every write, including writes that must not change it. Unmapped and misaligned addresses are mixed into the random traffic, so an aliasing decode surfaces as a corrupted register on a later read.

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int RAISE_BIT = 29,
  parameter int CTRL_DROP_BIT = 16,
  parameter int STAT_DROP_LO = 16,
  parameter int STAT_DROP_HI = 29,
  parameter int CTRL_ONE_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_DA  = AW'('h028);
  localparam logic [AW-1:0] OFF_DB  = AW'('h02C);
  localparam logic [AW-1:0] OFF_CTL = AW'('h04C);
  localparam logic [AW-1:0] OFF_ST  = AW'('h050);
  localparam logic [AW-1:0] OFF_SET = AW'('h1F0);
  localparam logic [AW-1:0] OFF_CLR = AW'('h1F4);
  localparam logic [DW-1:0] ONE_MASK = DW'(1) << CTRL_ONE_BIT;

  logic [AW-1:0] wa;
  logic [DW-1:0] desc_a, desc_b, ctl, stat, sw;
  logic hit_da, hit_db, hit_ctl, hit_st, hit_set, hit_clr;
  logic raise, drop;

  assign wa      = addr & ~AW'(3);
  assign hit_da  = wa == OFF_DA;
  assign hit_db  = wa == OFF_DB;
  assign hit_ctl = wa == OFF_CTL;
  assign hit_st  = wa == OFF_ST;
  assign hit_set = wa == OFF_SET;
  assign hit_clr = wa == OFF_CLR;

  assign raise = wr_en & ((hit_db & wr_data[RAISE_BIT]) | hit_set);
  assign drop  = wr_en & ((hit_ctl & wr_data[CTRL_DROP_BIT]) |
                          (hit_st & (wr_data[STAT_DROP_LO] | wr_data[STAT_DROP_HI])) |
                          hit_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_a <= '0;
      desc_b <= '0;
      ctl    <= '0;
      stat   <= '0;
      sw     <= '0;
    end else if (wr_en) begin
      if (hit_da)  desc_a <= wr_data;
      if (hit_db)  desc_b <= wr_data;
      if (hit_ctl) ctl    <= wr_data;
      if (hit_st)  stat   <= wr_data;
      if (hit_set) sw     <= sw | wr_data;
      if (hit_clr) sw     <= sw & ~wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (drop)  irq <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_da)              rd_data = desc_a;
      if (hit_db)              rd_data = desc_b;
      if (hit_ctl)             rd_data = ctl | ONE_MASK;
      if (hit_st)              rd_data = stat;
      if (hit_set || hit_clr)  rd_data = sw;
    end
  end
endmodule

module doorbell_regs_chk #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          irq
);
  logic [AW-1:0] wa;
  logic mapped;
  assign wa = addr & ~AW'(3);
  assign mapped = wa == AW'('h028) || wa == AW'('h02C) || wa == AW'('h04C) ||
                  wa == AW'('h050) || wa == AW'('h1F0) || wa == AW'('h1F4);

  // R3
  db_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wa == AW'('h02C) && wr_data[29] |=> irq);
  // R4
  ctl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && wa == AW'('h04C) |-> rd_data[17]);
  // R6
  set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wa == AW'('h1F0) |=> irq);
  // R7
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wa == AW'('h1F4) |=> !irq);
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !mapped |-> rd_data == '0);
  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !mapped |=> $stable(irq));
  // R11
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq));
endmodule

bind doorbell_regs doorbell_regs_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_doorbell_regs.sv
module tb_doorbell_regs;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int n_vec = 0, n_bad = 0;
  logic [31:0] m_a = 0, m_b = 0, m_ctl = 0, m_st = 0, m_sw = 0;
  logic m_irq = 0;

  always #2 clk = ~clk;

  doorbell_regs #(.AW(AW)) dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    case (a & ~AW'(3))
      AW'('h028): return m_a;
      AW'('h02C): return m_b;
      AW'('h04C): return m_ctl | 32'h0002_0000;
      AW'('h050): return m_st;
      AW'('h1F0), AW'('h1F4): return m_sw;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(input logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return "R10";
    case (a)
      AW'('h028): return "R2";
      AW'('h02C): return "R3";
      AW'('h04C): return "R4";
      AW'('h050): return "R5";
      AW'('h1F0): return "R6";
      AW'('h1F4): return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [31:0] d);
    case (a & ~AW'(3))
      AW'('h028): m_a = d;
      AW'('h02C): begin m_b = d; if (d[29]) m_irq = 1; end
      AW'('h04C): begin m_ctl = d; if (d[16]) m_irq = 0; end
      AW'('h050): begin m_st = d; if (d[16] || d[29]) m_irq = 0; end
      AW'('h1F0): begin m_sw = m_sw | d; m_irq = 1; end
      AW'('h1F4): begin m_sw = m_sw & ~d; m_irq = 0; end
      default: ;
    endcase
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
    chk({tag(a), " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic do_rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1;
    chk({tag(a), "/R8 read"}, rd_data, exp_rd(a));
    rd_en = 0;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [AW-1:0] a;
    case ($urandom_range(0, 8))
      0: a = AW'('h028);
      1: a = AW'('h02C);
      2: a = AW'('h04C);
      3: a = AW'('h050);
      4: a = AW'('h1F0);
      5: a = AW'('h1F4);
      6: a = AW'($urandom);
      default: a = AW'('h1F0) + AW'(4 * $urandom_range(0, 1));
    endcase
    if ($urandom_range(0, 7) == 0) a = a | AW'($urandom_range(1, 3));
    return a;
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_en = 1; addr = AW'('h04C); #1;
    chk("R1 ctl", rd_data, 32'h0002_0000);
    addr = AW'('h1F4); #1;
    chk("R1 sw", rd_data, 32'h0);
    rd_en = 0;
    @(negedge clk); rst_n = 1;
    // R11 read data zero without strobe
    addr = AW'('h04C); #1;
    chk("R11 idle", rd_data, 32'h0);
    // directed corners
    do_wr(AW'('h1F0), 32'h0);          // R6 zero data still raises
    do_wr(AW'('h028), 32'hFFFF_FFFF);  // R2 keeps irq
    do_wr(AW'('h300), 32'hFFFF_FFFF);  // R9 unmapped write keeps irq
    do_rd(AW'('h300));                 // R9
    repeat (3) @(negedge clk);
    chk("R11 hold", {31'b0, irq}, 32'h1);
    do_wr(AW'('h1F4), 32'h0);          // R7 zero data still lowers
    do_wr(AW'('h02C), 32'hDFFF_FFFF);  // R3 bit29 clear keeps low
    do_wr(AW'('h02D), 32'h2000_0000);  // R10 misaligned raise
    do_wr(AW'('h050), 32'hDFFE_FFFF);  // R5 no drop bits
    do_wr(AW'('h050), 32'h2000_0000);  // R5 bit29 drops
    do_wr(AW'('h1F0), 32'h00F0_00F0);
    do_wr(AW'('h04C), 32'hFFFE_FFFF);  // R4 bit16 clear keeps
    do_wr(AW'('h04C), 32'h0001_0000);  // R4 bit16 drops
    do_rd(AW'('h04C));
    do_rd(AW'('h1F0));                 // R8
    do_rd(AW'('h1F7));                 // R8 R10
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a = pick_addr();
      if ($urandom_range(0, 1) == 0) begin
        logic [31:0] d = $urandom;
        if ($urandom_range(0, 2) == 0) d = d & 32'hDFFE_FFFF;
        do_wr(a, d);
      end else
        do_rd(a);
    end
    finish_run();
  end
endmodule